// File: doc/BRIEF.md
# Bitplane Tile Output Formatter

This block sits between a bit-serial run-length decoder and a host that reads decompressed graphics one byte at a time. It asks the decoder for bits, one plane at a time, keeps an eight-bit history for each plane, and packs the results into a 64-byte tile buffer. The host then drains that buffer one byte per read.

A stream opens with a start strobe that carries the stream's depth code. The code selects one of four layouts. Codes 0, 2 and 1 are interleaved-bitplane layouts with 2, 4 and 8 planes. Code 3 is a byte-per-pixel layout with 8 planes. A tile is decoded only when a read finds the read position at zero. That read is stalled until the whole tile is in the buffer. Reads at any other position are answered from the buffer on the next cycle.

Top module: `tile_fmt`

## Requirements
- R1: After reset, and whenever no tile is being decoded, `bit_req_o` is low. After reset, `rd_valid_o` stays low until a read is made.
- R2: A read at position zero makes the block request a whole tile before it answers: 128 bits for depth code 0, 256 for code 2, and 512 for codes 1 and 3. A read at any other position requests no bits and sets `rd_valid_o` in the cycle after the strobe.
- R3: Interleaved layouts (codes 0, 2, 1). Planes are taken in pairs (p, p+1) with p even, starting from pair 0. Each pair covers 8 rows, and each row is 8 requests to plane p, each followed by one to plane p+1. At the end of a row, the last 8 bits of plane p go to byte p*8+row*2 and those of plane p+1 go to the next byte. The oldest bit of a row sits in bit 7.
- R4: Byte-per-pixel layout (code 3). Byte i is built from one request to each of planes 0 to 7, in that order. The bit from plane k is placed at bit k, and plane k's i-th bit of the tile is the one used.
- R5: Each answered read advances the position by one. The position wraps to zero after byte 15 (code 0), byte 31 (code 2) or byte 63 (codes 1 and 3), so the next read decodes a new tile.
- R6: Every accepted read produces exactly one `rd_valid_o` pulse, one cycle wide. A read strobe that arrives while an earlier read is still pending is ignored and does not move the position.
- R7: `start_i` sets the position to zero, latches `mode_i` for the stream and drops any tile decode in progress. `mode_i` has no effect at any other time.
- R8: A bit is transferred on a cycle where both `bit_req_o` and `bit_valid_i` are high. While a request waits, `bit_req_o` and `bit_plane_o` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Stream start strobe |
| mode_i | input | 2 | Depth code, latched when `start_i` is high |
| rd_i | input | 1 | Byte read strobe |
| rd_valid_o | output | 1 | One-cycle pulse: `rd_data_o` holds the byte that was read |
| rd_data_o | output | 8 | Byte returned to the host |
| bit_req_o | output | 1 | Bit request to the decoder |
| bit_plane_o | output | 3 | Plane the requested bit belongs to |
| bit_valid_i | input | 1 | Decoder presents a bit |
| bit_i | input | 1 | Decoded bit |

## Verification
The bench builds the block with its default geometry: 8-pixel rows and up to 8 planes, which gives a 64-byte buffer. Every depth code is exercised, including the 16-byte and 32-byte wraps that start a second tile. The decoder model holds back one cycle in three, so requests that wait are covered. Its bits depend on the plane and on that plane's running bit count, so a plane taken out of order, or a bit at the wrong position, changes the expected bytes. Reads that overlap a decode, and a restart in the middle of a decode, are also driven.

// File: rtl/tile_fmt_pkg.sv
package tile_fmt_pkg;
  localparam int TILE_DIM   = 8;
  localparam int MAX_PLANES = 8;
  localparam int BUF_BYTES  = TILE_DIM * MAX_PLANES;
  localparam int AW         = $clog2(BUF_BYTES);
  localparam int PW         = $clog2(MAX_PLANES);
  localparam int RW         = $clog2(TILE_DIM);

  typedef enum logic [1:0] {
    DEPTH_2P     = 2'd0,
    DEPTH_8P     = 2'd1,
    DEPTH_4P     = 2'd2,
    DEPTH_CHUNKY = 2'd3
  } depth_e;

  function automatic logic [AW-1:0] wrap_mask(depth_e d);
    case (d)
      DEPTH_2P: return AW'(TILE_DIM * 2 - 1);
      DEPTH_4P: return AW'(TILE_DIM * 4 - 1);
      default:  return AW'(BUF_BYTES - 1);
    endcase
  endfunction

  function automatic logic [PW-2:0] last_pair(depth_e d);
    case (d)
      DEPTH_2P: return (PW-1)'(0);
      DEPTH_4P: return (PW-1)'(1);
      default:  return (PW-1)'(MAX_PLANES / 2 - 1);
    endcase
  endfunction
endpackage

// File: rtl/tile_seq.sv
module tile_seq
  import tile_fmt_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          abort_i,
  input  logic          go_i,
  input  depth_e        depth_i,
  input  logic          bit_valid_i,
  output logic          bit_req_o,
  output logic [PW-1:0] plane_o,
  output logic          acc_o,
  output logic          wr_pair_o,
  output logic          wr_chunky_o,
  output logic [AW-1:0] wr_addr_o,
  output logic          done_o
);
  logic          busy_q;
  logic [PW-2:0] pair_q;
  logic          sub_q;
  logic [RW-1:0] row_q, x_q;
  logic [PW-1:0] k_q;
  logic [AW-1:0] byte_q;
  logic          chunky, row_end;

  assign chunky      = (depth_i == DEPTH_CHUNKY);
  assign bit_req_o   = busy_q;
  assign acc_o       = busy_q & bit_valid_i;
  assign row_end     = acc_o & ~chunky & sub_q & (x_q == RW'(TILE_DIM - 1));
  assign wr_pair_o   = row_end;
  assign wr_chunky_o = acc_o & chunky & (k_q == PW'(MAX_PLANES - 1));
  assign done_o      = (row_end & (row_q == RW'(TILE_DIM - 1)) & (pair_q == last_pair(depth_i)))
                     | (wr_chunky_o & (byte_q == AW'(BUF_BYTES - 1)));
  assign plane_o     = chunky ? k_q : {pair_q, sub_q};
  assign wr_addr_o   = chunky ? byte_q : {pair_q, row_q, 1'b0};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      pair_q <= '0;
      sub_q  <= 1'b0;
      row_q  <= '0;
      x_q    <= '0;
      k_q    <= '0;
      byte_q <= '0;
    end else if (abort_i) begin
      busy_q <= 1'b0;
    end else if (go_i) begin
      busy_q <= 1'b1;
      pair_q <= '0;
      sub_q  <= 1'b0;
      row_q  <= '0;
      x_q    <= '0;
      k_q    <= '0;
      byte_q <= '0;
    end else if (acc_o) begin
      if (done_o) busy_q <= 1'b0;
      if (chunky) begin
        k_q <= k_q + 1'b1;
        if (wr_chunky_o) byte_q <= byte_q + 1'b1;
      end else begin
        sub_q <= ~sub_q;
        if (sub_q) begin
          x_q <= x_q + 1'b1;
          if (row_end) begin
            row_q <= row_q + 1'b1;
            if (row_q == RW'(TILE_DIM - 1)) pair_q <= pair_q + 1'b1;
          end
        end
      end
    end
  end

  // R8
  handshake_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_req_o && !bit_valid_i && !abort_i) |=> (bit_req_o && $stable(plane_o)));

  // R2
  done_stops_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !bit_req_o);
endmodule

// File: rtl/tile_store.sv
module tile_store
  import tile_fmt_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  acc_i,
  input  logic [PW-1:0]         plane_i,
  input  logic                  bit_i,
  input  logic                  wr_pair_i,
  input  logic                  wr_chunky_i,
  input  logic [AW-1:0]         wr_addr_i,
  input  logic [AW-1:0]         rd_addr_i,
  output logic [TILE_DIM-1:0]   rd_data_o
);
  logic [MAX_PLANES-1:0][TILE_DIM-1:0] hist_q, hist_nxt;
  logic [TILE_DIM-1:0]                 buf_q [BUF_BYTES];
  logic [MAX_PLANES-1:0]               chunky_byte;
  logic [PW-1:0]                       even_plane;

  assign even_plane = {plane_i[PW-1:1], 1'b0};

  always_comb begin
    for (int q = 0; q < MAX_PLANES; q++) begin
      hist_nxt[q]    = (acc_i && plane_i == PW'(q)) ? {hist_q[q][TILE_DIM-2:0], bit_i} : hist_q[q];
      chunky_byte[q] = hist_nxt[q][0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= '0;
      for (int e = 0; e < BUF_BYTES; e++) buf_q[e] <= '0;
    end else begin
      hist_q <= hist_nxt;
      if (wr_pair_i) begin
        buf_q[wr_addr_i]            <= hist_q[even_plane];
        buf_q[wr_addr_i | AW'(1)]   <= hist_nxt[plane_i];
      end else if (wr_chunky_i) begin
        buf_q[wr_addr_i] <= TILE_DIM'(chunky_byte);
      end
    end
  end

  assign rd_data_o = buf_q[rd_addr_i];

  // R3
  row_end_odd_plane_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_pair_i |-> (plane_i[0] && acc_i && !wr_addr_i[0]));

  // R4
  chunky_last_plane_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_chunky_i |-> (plane_i == PW'(MAX_PLANES - 1) && acc_i));
endmodule

// File: rtl/tile_fmt.sv
module tile_fmt
  import tile_fmt_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [1:0] mode_i,
  input  logic       rd_i,
  output logic       rd_valid_o,
  output logic [7:0] rd_data_o,
  output logic       bit_req_o,
  output logic [2:0] bit_plane_o,
  input  logic       bit_valid_i,
  input  logic       bit_i
);
  typedef enum logic [1:0] {ST_IDLE, ST_DECODE, ST_FETCH} state_e;

  state_e               state_q;
  depth_e               mode_q;
  logic [AW-1:0]        pos_q, mask;
  logic                 rd_valid_q;
  logic [TILE_DIM-1:0]  rd_data_q, buf_byte;
  logic                 go, acc, wr_pair, wr_chunky, done;
  logic [PW-1:0]        plane;
  logic [AW-1:0]        wr_addr;

  assign mask = wrap_mask(mode_q);
  assign go   = (state_q == ST_IDLE) & rd_i & (pos_q == '0) & ~start_i;

  tile_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .abort_i     (start_i),
    .go_i        (go),
    .depth_i     (mode_q),
    .bit_valid_i (bit_valid_i),
    .bit_req_o   (bit_req_o),
    .plane_o     (plane),
    .acc_o       (acc),
    .wr_pair_o   (wr_pair),
    .wr_chunky_o (wr_chunky),
    .wr_addr_o   (wr_addr),
    .done_o      (done)
  );

  tile_store u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .acc_i       (acc),
    .plane_i     (plane),
    .bit_i       (bit_i),
    .wr_pair_i   (wr_pair),
    .wr_chunky_i (wr_chunky),
    .wr_addr_i   (wr_addr),
    .rd_addr_i   (pos_q),
    .rd_data_o   (buf_byte)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      mode_q     <= DEPTH_2P;
      pos_q      <= '0;
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= 1'b0;
      if (start_i) begin
        mode_q  <= depth_e'(mode_i);
        pos_q   <= '0;
        state_q <= ST_IDLE;
      end else begin
        case (state_q)
          ST_IDLE: if (rd_i) begin
            if (pos_q == '0) state_q <= ST_DECODE;
            else begin
              rd_data_q  <= buf_byte;
              rd_valid_q <= 1'b1;
              pos_q      <= (pos_q + 1'b1) & mask;
            end
          end
          ST_DECODE: if (done) state_q <= ST_FETCH;
          default: begin
            rd_data_q  <= buf_byte;
            rd_valid_q <= 1'b1;
            pos_q      <= (pos_q + 1'b1) & mask;
            state_q    <= ST_IDLE;
          end
        endcase
      end
    end
  end

  assign rd_valid_o  = rd_valid_q;
  assign rd_data_o   = 8'(rd_data_q);
  assign bit_plane_o = 3'(plane);

  // R1
  idle_no_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> !bit_req_o);

  // R6
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |=> !rd_valid_o);

  // R5
  pos_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pos_q & ~mask) == '0);

  // R7
  start_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (pos_q == '0 && !rd_valid_o && !bit_req_o));
endmodule

// File: tb/tile_fmt_test.sv
module tile_fmt_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [1:0] mode_i = 2'd0;
  logic       rd_i = 1'b0;
  logic       rd_valid_o;
  logic [7:0] rd_data_o;
  logic       bit_req_o;
  logic [2:0] bit_plane_o;
  logic       bit_valid_i;
  logic       bit_i;

  int tests = 0, fails = 0;
  int cyc = 0;
  int dec_cnt [8];
  int dec_total = 0;
  int tbase [8];
  int bmode = 0, bpos = 0, bmask = 15;

  always #2 clk_i = ~clk_i;

  tile_fmt uut (.*);

  function automatic logic fbit(int q, int n);
    int v;
    v = (n * 3 + q * 5 + (n >> 3)) ^ (n >> 5);
    return v[1];
  endfunction

  initial for (int q = 0; q < 8; q++) dec_cnt[q] = 0;

  assign bit_valid_i = bit_req_o && (cyc % 3 != 1);
  assign bit_i       = fbit(int'(bit_plane_o), dec_cnt[bit_plane_o]);

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (bit_req_o && bit_valid_i) begin
      dec_cnt[bit_plane_o] <= dec_cnt[bit_plane_o] + 1;
      dec_total <= dec_total + 1;
    end
  end

  function automatic int mask_of(int md);
    return md == 0 ? 15 : (md == 2 ? 31 : 63);
  endfunction

  function automatic int tile_bits(int md);
    return md == 0 ? 128 : (md == 2 ? 256 : 512);
  endfunction

  function automatic logic [7:0] exp_byte(int md, int a);
    logic [7:0] b;
    int q, row;
    if (md == 3) begin
      for (int k = 0; k < 8; k++) b[k] = fbit(k, tbase[k] + a);
    end else begin
      row = (a % 16) / 2;
      q   = (a / 16) * 2 + (a % 2);
      for (int j = 0; j < 8; j++) b[7-j] = fbit(q, tbase[q] + row * 8 + j);
    end
    return b;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  task automatic do_start(input int md);
    @(negedge clk_i);
    start_i = 1'b1;
    mode_i  = 2'(md);
    @(negedge clk_i);
    start_i = 1'b0;
    mode_i  = ~2'(md);
    bmode = md;
    bpos  = 0;
    bmask = mask_of(md);
  endtask

  task automatic do_read(output logic [7:0] d, output int lat);
    @(negedge clk_i);
    rd_i = 1'b1;
    @(negedge clk_i);
    rd_i = 1'b0;
    lat = 0;
    while (!rd_valid_o && lat < 5000) begin
      @(negedge clk_i);
      lat++;
    end
    d = rd_data_o;
  endtask

  task automatic rd_check(input string req);
    logic [7:0] d;
    int lat, bits0;
    bit dec;
    dec = (bpos == 0);
    if (dec) for (int q = 0; q < 8; q++) tbase[q] = dec_cnt[q];
    bits0 = dec_total;
    do_read(d, lat);
    chk(req, $sformatf("byte %0d mode %0d", bpos, bmode), int'(d), int'(exp_byte(bmode, bpos)));
    if (dec) chk("R2", "tile bits", dec_total - bits0, tile_bits(bmode));
    else begin
      chk("R2", "hit latency", lat, 0);
      chk("R2", "hit bits", dec_total - bits0, 0);
    end
    bpos = (bpos + 1) & bmask;
  endtask

  task automatic t_reset();
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i);
      chk("R1", "valid after reset", int'(rd_valid_o), 0);
      chk("R1", "req after reset", int'(bit_req_o), 0);
    end
  endtask

  task automatic t_planar(input int md, input string req);
    do_start(md);
    for (int i = 0; i <= mask_of(md); i++) rd_check(req);
    chk("R5", "wrapped position", bpos, 0);
    rd_check("R5");
    rd_check("R5");
  endtask

  task automatic t_chunky();
    do_start(3);
    for (int i = 0; i < 64; i++) rd_check("R4");
    rd_check("R5");
  endtask

  task automatic t_busy();
    int nv;
    logic [7:0] d;
    do_start(1);
    for (int q = 0; q < 8; q++) tbase[q] = dec_cnt[q];
    @(negedge clk_i); rd_i = 1'b1;
    @(negedge clk_i); rd_i = 1'b0;
    repeat (5) @(negedge clk_i);
    chk("R6", "stalled valid", int'(rd_valid_o), 0);
    rd_i = 1'b1;
    @(negedge clk_i); rd_i = 1'b0;
    nv = 0;
    d = '0;
    repeat (1200) begin
      @(negedge clk_i);
      if (rd_valid_o) begin nv++; d = rd_data_o; end
    end
    chk("R6", "valid pulses", nv, 1);
    chk("R6", "stalled byte", int'(d), int'(exp_byte(1, 0)));
    bpos = 1;
    rd_check("R6");
  endtask

  task automatic t_start();
    do_start(2);
    for (int i = 0; i < 3; i++) rd_check("R7");
    do_start(0);
    for (int i = 0; i < 16; i++) rd_check("R7");
    do_start(1);
    @(negedge clk_i); rd_i = 1'b1;
    @(negedge clk_i); rd_i = 1'b0;
    repeat (20) @(negedge clk_i);
    chk("R8", "req during decode", int'(bit_req_o), 1);
    do_start(0);
    chk("R7", "req after restart", int'(bit_req_o), 0);
    repeat (3) @(negedge clk_i);
    chk("R7", "valid after restart", int'(rd_valid_o), 0);
    for (int i = 0; i < 16; i++) rd_check("R7");
    rd_check("R7");
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_planar(0, "R3");
    t_planar(2, "R3");
    t_planar(1, "R3");
    t_chunky();
    t_busy();
    t_start();
    summary();
  end
endmodule